// File: doc/BRIEF.md
# Hashed Reader-Writer Lock Directory

This block serialises memory-side operations that each touch a single 64-byte cache block. A requester presents a byte address and asks for shared (read) or exclusive (write) access. The block address, with the six offset bits removed, is folded by an XOR hash into an index into one table of reader-writer locks. Every in-flight operation uses this one table. Two unrelated blocks can land on the same lock. That only serialises them more than strictly needed, and it never lets two conflicting operations overlap.

A request that cannot be granted keeps `reqReady` low until the lock frees. There is no internal queue. When an operation finishes, it returns its lock through a separate release port that carries the same address and access type. A fence request is acknowledged only when no lock is held anywhere and no grant happens in that cycle. This lets ordinary loads and stores be ordered behind all earlier operations. A release of a lock that is not held sets a sticky error flag and leaves the table unchanged.

Top module: `rwLockDir`

## Requirements
- R1: After reset every entry is free: `reqReady` is high for any read or write address, `fenceAck` follows `fenceReq`, and `relErr` is 0.
- R2: The lock index is the XOR of the 11-bit slices of address bits [47:6], with the slice at bits [16:6] as slice 0. The low six address bits never affect the index. Addresses with equal folded values contend, and addresses with different folded values do not.
- R3: A read is grantable while the entry has no writer, so several readers share one entry. A write is not grantable while the reader count is nonzero.
- R4: A write is grantable only when the entry has no readers and no writer. While a writer holds an entry, both read and write requests to it stall.
- R5: The reader count per entry is 4 bits wide. When it is at 15, a further read stalls instead of wrapping.
- R6: A read release decrements the entry's count and a write release clears its writer flag, after which waiting requests to that entry become grantable in the next cycle.
- R7: A release of a read on an entry with count 0, or of a write on an entry without a writer, sets `relErr`. The flag stays high until reset, and the table is not changed.
- R8: `fenceAck` is high only while `fenceReq` is high, no lock is held in the whole table, and no request is granted in the same cycle.
- R9: When a request and a release hit the same entry in one cycle, the grant decision uses the state before the release, and both updates are applied together at the clock edge.
- R10: A request is granted in a cycle where `reqValid` and `reqReady` are both high. `reqReady` reflects whether the presented request can be granted now.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lock request present |
| reqWrite | input | 1 | 1 = exclusive (write) lock, 0 = shared (read) lock |
| reqAddr | input | 48 | Byte address of the requested block |
| reqReady | output | 1 | Presented request can be granted this cycle |
| relValid | input | 1 | Lock release present |
| relWrite | input | 1 | 1 = release a write lock, 0 = release a read lock |
| relAddr | input | 48 | Byte address of the released block |
| fenceReq | input | 1 | Fence waiting for all locks to drain |
| fenceAck | output | 1 | Fence may complete |
| relErr | output | 1 | Sticky flag: a release of an unheld lock occurred |

## Verification
A grant and a release can both happen in one cycle, and they can target the same entry. The bench provokes this with a read request against an entry whose writer is being released in that cycle. It expects `reqReady` to stay low in that cycle and to rise in the next. A fence can coincide with a grant when the table is empty. The bench presents both together and expects no acknowledge in that cycle. Aliasing is provoked with two block addresses whose slices fold to the same index. The bench judges it by whether the second one stalls.

// File: rtl/rwLockPkg.sv
package rwLockPkg;
  typedef struct packed {
    logic grantRd;
    logic grantWr;
    logic relRd;
    logic relWr;
  } lockStrobe_t;
endpackage

// File: rtl/rwLockHash.sv
module rwLockHash #(
  parameter int ADDR_W = 48,
  parameter int OFF_W  = 6,
  parameter int IDX_W  = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int NSLICE = (BLK_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NSLICE * IDX_W;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(addr[ADDR_W-1:OFF_W]);

  always_comb begin
    idx = '0;
    for (int s = 0; s < NSLICE; s++) begin
      idx = idx ^ padded[s*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/rwLockStore.sv
module rwLockStore
  import rwLockPkg::*;
#(
  parameter int IDX_W = 11,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  lockStrobe_t      strobe,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic [IDX_W-1:0] relIdx,
  output logic [CNT_W-1:0] reqCnt,
  output logic             reqWrFlag,
  output logic [CNT_W-1:0] relCnt,
  output logic             relWrFlag
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [CNT_W-1:0]   cntTbl [ENTRIES];
  logic [ENTRIES-1:0] wrTbl;

  logic [CNT_W-1:0] relCntNext, baseCnt, reqCntNext;
  logic             relWrNext, baseWr, reqWrNext;
  logic             relAny, grantAny, sameIdx;

  assign reqCnt    = cntTbl[reqIdx];
  assign reqWrFlag = wrTbl[reqIdx];
  assign relCnt    = cntTbl[relIdx];
  assign relWrFlag = wrTbl[relIdx];

  assign relAny   = strobe.relRd | strobe.relWr;
  assign grantAny = strobe.grantRd | strobe.grantWr;
  assign sameIdx  = relAny && (reqIdx == relIdx);

  always_comb begin
    relCntNext = relCnt - CNT_W'(strobe.relRd);
    relWrNext  = strobe.relWr ? 1'b0 : relWrFlag;
    baseCnt    = sameIdx ? relCntNext : reqCnt;
    baseWr     = sameIdx ? relWrNext  : reqWrFlag;
    reqCntNext = baseCnt + CNT_W'(strobe.grantRd);
    reqWrNext  = baseWr | strobe.grantWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) cntTbl[e] <= '0;
      wrTbl <= '0;
    end else begin
      if (relAny) begin
        cntTbl[relIdx] <= relCntNext;
        wrTbl[relIdx]  <= relWrNext;
      end
      if (grantAny) begin
        cntTbl[reqIdx] <= reqCntNext;
        wrTbl[reqIdx]  <= reqWrNext;
      end
    end
  end

  // R4
  wr_grant_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grantWr |=> wrTbl[$past(reqIdx)]);
  // R5
  rd_grant_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grantRd |=> cntTbl[$past(reqIdx)] != '0);
  // R6
  wr_release_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.relWr |=> !wrTbl[$past(relIdx)]);
endmodule

// File: rtl/rwLockCtrl.sv
module rwLockCtrl
  import rwLockPkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int HELD_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [CNT_W-1:0] reqCnt,
  input  logic             reqWrFlag,
  input  logic             relValid,
  input  logic             relWrite,
  input  logic [CNT_W-1:0] relCnt,
  input  logic             relWrFlag,
  input  logic             fenceReq,
  output logic             reqReady,
  output lockStrobe_t      strobe,
  output logic             fenceAck,
  output logic             relErr
);
  logic              canRead, canWrite, grant, relOk, relGood;
  logic [HELD_W-1:0] heldCount;

  assign canRead  = !reqWrFlag && (reqCnt != '1);
  assign canWrite = !reqWrFlag && (reqCnt == '0);
  assign reqReady = reqWrite ? canWrite : canRead;
  assign grant    = reqValid && reqReady;

  assign relOk   = relWrite ? relWrFlag : (relCnt != '0);
  assign relGood = relValid && relOk;

  always_comb begin
    strobe.grantRd = grant && !reqWrite;
    strobe.grantWr = grant && reqWrite;
    strobe.relRd   = relGood && !relWrite;
    strobe.relWr   = relGood && relWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldCount <= '0;
      relErr    <= 1'b0;
    end else begin
      heldCount <= heldCount + HELD_W'(grant) - HELD_W'(relGood);
      if (relValid && !relOk) relErr <= 1'b1;
    end
  end

  assign fenceAck = fenceReq && (heldCount == '0) && !grant;

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    relErr |=> relErr);
  // R7
  bad_release_no_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    (relValid && !relOk) |-> !(strobe.relRd || strobe.relWr));
endmodule

// File: rtl/rwLockDir.sv
module rwLockDir
  import rwLockPkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int OFF_W  = 6,
  parameter int IDX_W  = 11,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  input  logic              relValid,
  input  logic              relWrite,
  input  logic [ADDR_W-1:0] relAddr,
  input  logic              fenceReq,
  output logic              fenceAck,
  output logic              relErr
);
  localparam int HELD_W = IDX_W + CNT_W + 1;

  logic [IDX_W-1:0] reqIdx, relIdx;
  logic [CNT_W-1:0] reqCnt, relCnt;
  logic             reqWrFlag, relWrFlag;
  lockStrobe_t      strobe;

  rwLockHash #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_reqHash (
    .addr(reqAddr), .idx(reqIdx));
  rwLockHash #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_relHash (
    .addr(relAddr), .idx(relIdx));

  rwLockStore #(.IDX_W(IDX_W), .CNT_W(CNT_W)) i_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqIdx(reqIdx), .relIdx(relIdx),
    .reqCnt(reqCnt), .reqWrFlag(reqWrFlag),
    .relCnt(relCnt), .relWrFlag(relWrFlag));

  rwLockCtrl #(.CNT_W(CNT_W), .HELD_W(HELD_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCnt(reqCnt), .reqWrFlag(reqWrFlag),
    .relValid(relValid), .relWrite(relWrite),
    .relCnt(relCnt), .relWrFlag(relWrFlag),
    .fenceReq(fenceReq), .reqReady(reqReady), .strobe(strobe),
    .fenceAck(fenceAck), .relErr(relErr));

  // R8
  fence_sees_free_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    fenceAck |-> (reqCnt == '0) && !reqWrFlag);
endmodule

// File: tb/test_rwLockDir.sv
module test_rwLockDir;
  localparam int ADDR_W = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, relValid = 1'b0, relWrite = 1'b0, fenceReq = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0, relAddr = '0;
  logic reqReady, fenceAck, relErr;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 1'b0;

  typedef struct {
    string tag;
    bit    expReady;
    bit    expAck;
    bit    expErr;
  } item_t;
  item_t sbQ[$];

  always #5 clk = ~clk;

  rwLockDir i_rwLockDir (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqReady(reqReady), .relValid(relValid),
    .relWrite(relWrite), .relAddr(relAddr), .fenceReq(fenceReq),
    .fenceAck(fenceAck), .relErr(relErr));

  // Addresses: A and B fold to index 1 (aliased), C folds to index 2.
  localparam logic [ADDR_W-1:0] ADDR_A = 48'h1 << 17;
  localparam logic [ADDR_W-1:0] ADDR_B = 48'h1 << 28;
  localparam logic [ADDR_W-1:0] ADDR_C = 48'h2 << 6;

  task automatic step(input bit v, input bit w, input logic [ADDR_W-1:0] a,
                      input bit rv, input bit rw, input logic [ADDR_W-1:0] ra,
                      input bit f, input bit eR, input bit eA, input bit eE,
                      input string tag);
    item_t it;
    @(negedge clk);
    reqValid = v; reqWrite = w; reqAddr = a;
    relValid = rv; relWrite = rw; relAddr = ra; fenceReq = f;
    #1;
    it.tag = tag; it.expReady = eR; it.expAck = eA; it.expErr = eE;
    sbQ.push_back(it);
  endtask

  // Monitor: pops expectations and compares the live outputs
  initial begin
    forever begin
      item_t it;
      wait (sbQ.size() > 0);
      it = sbQ.pop_front();
      checks += 3;
      if (reqReady !== it.expReady) begin
        errors++;
        $display("FAIL %s reqReady actual=%b expected=%b", it.tag, reqReady, it.expReady);
      end
      if (fenceAck !== it.expAck) begin
        errors++;
        $display("FAIL %s fenceAck actual=%b expected=%b", it.tag, fenceAck, it.expAck);
      end
      if (relErr !== it.expErr) begin
        errors++;
        $display("FAIL %s relErr actual=%b expected=%b", it.tag, relErr, it.expErr);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!doneFlag) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    step(0,0,'0, 0,0,'0, 1, 1,1,0, "R1 reset state");
    step(1,1,ADDR_A, 0,0,'0, 0, 1,0,0, "R10 write A granted");
    step(1,1,ADDR_B, 0,0,'0, 1, 0,0,0, "R2/R8 aliased write B stalls, fence held");
    step(1,1,ADDR_C, 0,0,'0, 0, 1,0,0, "R2 distinct write C granted");
    step(1,0,ADDR_A, 0,0,'0, 0, 0,0,0, "R4 read stalls on writer");
    step(1,0,ADDR_A, 1,1,ADDR_A | 48'h3F, 0, 0,0,0, "R9 read vs same-cycle write release");
    step(1,0,ADDR_A, 0,0,'0, 0, 1,0,0, "R9 read granted next cycle");
    step(1,1,ADDR_A, 0,0,'0, 0, 0,0,0, "R3 write stalls on reader");
    step(1,0,ADDR_B, 0,0,'0, 0, 1,0,0, "R3 shared read via alias");
    for (int i = 0; i < 13; i++)
      step(1,0,ADDR_A, 0,0,'0, 0, 1,0,0, "R5 read up to 15");
    step(1,0,ADDR_A, 0,0,'0, 0, 0,0,0, "R5 sixteenth read stalls");
    for (int i = 0; i < 15; i++)
      step(0,0,ADDR_A, 1,0,ADDR_A, 0, (i != 0),0,0, "R6 read release");
    step(0,1,ADDR_A, 1,1,ADDR_C, 0, 1,0,0, "R6 entry free for write");
    step(0,1,ADDR_C, 0,0,'0, 0, 1,0,0, "R6 write release frees C");
    step(0,1,ADDR_A, 1,0,ADDR_A, 0, 1,0,0, "R7 release of unheld read");
    step(1,1,ADDR_A, 0,0,'0, 1, 1,0,1, "R7/R8 error set, grant blocks ack");
    step(0,0,'0, 1,1,ADDR_A, 1, 1,0,1, "R8 lock still held");
    step(0,0,'0, 0,0,'0, 1, 1,1,1, "R8 drained ack, R7 sticky");
    @(negedge clk);
    wait (sbQ.size() == 0);
    #1;
    doneFlag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule